// File: doc/BRIEF.md
# Audio Controller Interrupt Aggregator

This block gathers every interrupt source of a multi-stream audio DMA controller into a single interrupt status word and a single level interrupt line. The response ring reports two flags, an interrupt flag and an overrun flag. Each of the eight streams reports a buffer-completion flag. The codecs report state changes, which the block records in its own sticky register. A wake-enable mask decides which of those recorded changes can raise an interrupt.

The status word is hierarchical. Bits 7:0 follow the per-stream completion flags. Bit 30 is a controller summary that merges the two ring flags with the enabled codec changes. Bit 31 is a global summary: it is set when any status bit meets its matching enable in the interrupt-control register. The line asserts only when that global summary is set and the global-enable bit (control bit 31) is also set.

Software reaches the block through a one-cycle write port. The port selects one of three registers: the interrupt-control register, the wake-enable mask, or the codec-change register. The codec-change register is cleared by writing 1 to a bit. The line itself comes from a two-state machine. It moves from `LINE_IDLE` to `LINE_ACTIVE` on the transition RAISE, when the status summary and the global enable are both set. It moves back on the transition DROP when that condition no longer holds.

Top module: `audio_irq_aggregator`

## Requirements
- R1: Status bit 30 is 1 exactly when the ring interrupt flag is set, or the ring overrun flag is set, or some codec-change bit is set together with its wake-enable bit.
- R2: Status bits 7:0 equal the stream completion inputs bit for bit. Status bits 29:8 always read 0.
- R3: Status bit 31 is 1 exactly when the AND of status bits 30:0 with control bits 30:0 is nonzero.
- R4: The interrupt line is registered. Its value one clock after a given cycle is 1 exactly when, in that cycle, status bit 31 and control bit 31 are both 1.
- R5: A write with select 2'b00 loads the interrupt-control register. Only bits 31, 30 and 7:0 take the written value; all other bits read 0.
- R6: A write with select 2'b10 clears each codec-change bit written as 1. A codec event input sets its bit. When an event and a clear hit the same bit in the same cycle, the event wins.
- R7: Synchronous active-high reset clears the control and wake-enable registers and the line. It loads the codec-change register with the attached-codec mask (default 15'h0005).
- R8: A write with select 2'b11 changes no register.
- R9: A write with select 2'b01 loads the 15-bit wake-enable mask from data bits 14:0.
- R10: If a write of 1 clears the last active source, the line falls on the clock after the register update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rsp_irq_i | input | 1 | Response-ring interrupt flag |
| rsp_ovr_i | input | 1 | Response-ring overrun flag |
| stream_done_i | input | 8 | Per-stream buffer-completion flags |
| codec_evt_i | input | 15 | Codec state-change event pulses, one per codec address |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write select: 00 control, 01 wake enable, 10 codec change (W1C), 11 none |
| wr_data_i | input | 32 | Write data |
| int_ctl_o | output | 32 | Interrupt-control register |
| wake_en_o | output | 15 | Wake-enable mask |
| codec_chg_o | output | 15 | Codec-change register |
| int_sts_o | output | 32 | Interrupt status word |
| irq_o | output | 1 | Level interrupt line |

## Verification
The hardest case to bring about is the codec-change path. A change can only reach bit 30 after it has been recorded in the sticky register and unmasked by a separate wake-enable write. It can only leave through a write-1 clear, which may race a new event on the same bit. The stimulus starts from the attached-codec value left by reset and walks several wake masks over it. It then issues a clear and an event on one bit in the same cycle, and finally clears the last live source to watch the line fall one clock later. The stream bits are swept over all 256 patterns under a range of enable masks, with and without the global enable.

// File: rtl/audio_irq_pkg.sv
package audio_irq_pkg;

    localparam int CTL_SUM_BIT = 30;
    localparam int GLOBAL_BIT  = 31;

    typedef enum logic [1:0] {
        SEL_CTL  = 2'b00,
        SEL_WAKE = 2'b01,
        SEL_CHG  = 2'b10,
        SEL_NONE = 2'b11
    } wsel_t;

    typedef enum logic {
        LINE_IDLE   = 1'b0,
        LINE_ACTIVE = 1'b1
    } line_state_t;

endpackage

// File: rtl/audio_irq_regs.sv
module audio_irq_regs
    import audio_irq_pkg::*;
#(
    parameter int NSTREAM = 8,
    parameter int NCODEC = 15,
    parameter logic [NCODEC-1:0] ATTACHED_MASK = 15'h0005
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  wsel_t             wr_sel,
    input  logic [31:0]       wr_data,
    input  logic [NCODEC-1:0] codec_evt,
    output logic [31:0]       int_ctl,
    output logic [NCODEC-1:0] wake_en,
    output logic [NCODEC-1:0] codec_chg
);

    localparam logic [31:0] STREAM_FIELD = (32'h1 << NSTREAM) - 32'h1;
    localparam logic [31:0] CTL_MASK =
        (32'h1 << GLOBAL_BIT) | (32'h1 << CTL_SUM_BIT) | STREAM_FIELD;

    logic [NCODEC-1:0] clr_bits;

    always_comb begin
        clr_bits = '0;
        if (wr_en && wr_sel == SEL_CHG) begin
            clr_bits = wr_data[NCODEC-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            int_ctl   <= '0;
            wake_en   <= '0;
            codec_chg <= ATTACHED_MASK;
        end else begin
            if (wr_en && wr_sel == SEL_CTL) begin
                int_ctl <= wr_data & CTL_MASK;
            end
            if (wr_en && wr_sel == SEL_WAKE) begin
                wake_en <= wr_data[NCODEC-1:0];
            end
            codec_chg <= (codec_chg & ~clr_bits) | codec_evt;
        end
    end

    assert_ctl_mask_R5: assert property (@(posedge clk) disable iff (rst)
        (int_ctl & ~CTL_MASK) == 32'h0);

    // A cleared bit stays clear unless an event arrived in the same cycle.
    assert_w1c_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_CHG) |=>
        ((codec_chg & $past(wr_data[NCODEC-1:0] & ~codec_evt)) == '0));

    assert_none_sel_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_NONE && codec_evt == '0) |=>
        ($stable(int_ctl) && $stable(wake_en) && $stable(codec_chg)));

endmodule

// File: rtl/audio_irq_status.sv
module audio_irq_status
    import audio_irq_pkg::*;
#(
    parameter int NSTREAM = 8,
    parameter int NCODEC = 15
) (
    input  logic               rsp_irq,
    input  logic               rsp_ovr,
    input  logic [NCODEC-1:0]  codec_chg,
    input  logic [NCODEC-1:0]  wake_en,
    input  logic [NSTREAM-1:0] stream_done,
    input  logic [31:0]        int_ctl,
    output logic [31:0]        int_sts
);

    logic [CTL_SUM_BIT-1:0] stream_field;
    logic                   ctl_summary;

    for (genvar i = 0; i < CTL_SUM_BIT; i++) begin : g_stream_bit
        if (i < NSTREAM) begin : g_live
            assign stream_field[i] = stream_done[i];
        end else begin : g_zero
            assign stream_field[i] = 1'b0;
        end
    end

    assign ctl_summary = rsp_irq | rsp_ovr | (|(codec_chg & wake_en));

    always_comb begin
        int_sts = {1'b0, ctl_summary, stream_field};
        int_sts[GLOBAL_BIT] = |(int_sts[30:0] & int_ctl[30:0]);
    end

    always_comb begin
        if (rsp_irq || rsp_ovr) begin
            assert_ring_sum_R1: assert (int_sts[CTL_SUM_BIT]);
        end
        if ((stream_done & int_ctl[NSTREAM-1:0]) != '0) begin
            assert_stream_global_R3: assert (int_sts[GLOBAL_BIT]);
        end
    end

endmodule

// File: rtl/audio_irq_line.sv
module audio_irq_line
    import audio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic summary,
    input  logic global_en,
    output logic irq
);

    line_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_IDLE:   if (summary && global_en)    state_d = LINE_ACTIVE; // RAISE
            LINE_ACTIVE: if (!(summary && global_en)) state_d = LINE_IDLE;   // DROP
            default:     state_d = LINE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= LINE_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == LINE_ACTIVE);
    end

    assert_line_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (summary && global_en) |=> irq);

    assert_line_fall_R10: assert property (@(posedge clk) disable iff (rst)
        !(summary && global_en) |=> !irq);

endmodule

// File: rtl/audio_irq_aggregator.sv
module audio_irq_aggregator
    import audio_irq_pkg::*;
#(
    parameter int NSTREAM = 8,
    parameter int NCODEC = 15,
    parameter logic [NCODEC-1:0] ATTACHED_MASK = 15'h0005
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rsp_irq_i,
    input  logic               rsp_ovr_i,
    input  logic [NSTREAM-1:0] stream_done_i,
    input  logic [NCODEC-1:0]  codec_evt_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_sel_i,
    input  logic [31:0]        wr_data_i,
    output logic [31:0]        int_ctl_o,
    output logic [NCODEC-1:0]  wake_en_o,
    output logic [NCODEC-1:0]  codec_chg_o,
    output logic [31:0]        int_sts_o,
    output logic               irq_o
);

    wsel_t       sel;
    logic [31:0] ctl_w;
    logic [31:0] sts_w;

    assign sel = wsel_t'(wr_sel_i);

    audio_irq_regs #(
        .NSTREAM(NSTREAM), .NCODEC(NCODEC), .ATTACHED_MASK(ATTACHED_MASK)
    ) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en_i), .wr_sel(sel), .wr_data(wr_data_i),
        .codec_evt(codec_evt_i),
        .int_ctl(ctl_w), .wake_en(wake_en_o), .codec_chg(codec_chg_o)
    );

    audio_irq_status #(.NSTREAM(NSTREAM), .NCODEC(NCODEC)) u_status (
        .rsp_irq(rsp_irq_i), .rsp_ovr(rsp_ovr_i),
        .codec_chg(codec_chg_o), .wake_en(wake_en_o),
        .stream_done(stream_done_i), .int_ctl(ctl_w),
        .int_sts(sts_w)
    );

    audio_irq_line u_line (
        .clk(clk), .rst(rst),
        .summary(sts_w[GLOBAL_BIT]), .global_en(ctl_w[GLOBAL_BIT]),
        .irq(irq_o)
    );

    assign int_ctl_o = ctl_w;
    assign int_sts_o = sts_w;

    assert_reset_line_R7: assert property (@(posedge clk)
        rst |=> !irq_o);

endmodule

// File: tb/audio_irq_aggregator_tb.sv
module audio_irq_aggregator_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        rsp_irq, rsp_ovr;
    logic [7:0]  sdone;
    logic [14:0] cevt;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic [31:0] ctl, sts;
    logic [14:0] wake, chg;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    audio_irq_aggregator u_dut (
        .clk(clk), .rst(rst),
        .rsp_irq_i(rsp_irq), .rsp_ovr_i(rsp_ovr),
        .stream_done_i(sdone), .codec_evt_i(cevt),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .int_ctl_o(ctl), .wake_en_o(wake), .codec_chg_o(chg),
        .int_sts_o(sts), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_sts(input logic ri, input logic ro,
            input logic [14:0] c, input logic [14:0] w,
            input logic [7:0] s, input logic [31:0] k);
        logic [31:0] v;
        v = {24'h0, s};
        v[30] = ri | ro | (|(c & w));
        v[31] = ((v & k & 32'h7fff_ffff) != 0);
        return v;
    endfunction

    // One write cycle; returns at the negedge after the register update.
    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'b11; wr_data = '0;
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] k;
        logic [14:0] wm [5];
        wm[0] = 15'h0000; wm[1] = 15'h0001; wm[2] = 15'h0002;
        wm[3] = 15'h0004; wm[4] = 15'h7fff;

        rst = 1'b1; rsp_irq = 0; rsp_ovr = 0; sdone = '0; cevt = '0;
        wr_en = 0; wr_sel = 2'b11; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R7 reset state
        chk("R7 ctl", ctl, 32'h0);
        chk("R7 wake", {17'h0, wake}, 32'h0);
        chk("R7 chg", {17'h0, chg}, 32'h5);
        chk("R7 sts", sts, 32'h0);
        chk("R7 irq", {31'h0, irq}, 32'h0);

        // R5 writable mask
        wr(2'b00, 32'hffff_ffff);
        chk("R5 ctl mask", ctl, 32'hc000_00ff);
        // R9 wake width
        wr(2'b01, 32'hffff_ffff);
        chk("R9 wake", {17'h0, wake}, 32'h7fff);
        // R8 no-op select
        wr(2'b11, 32'h0000_0000);
        chk("R8 ctl", ctl, 32'hc000_00ff);
        chk("R8 wake", {17'h0, wake}, 32'h7fff);
        chk("R8 chg", {17'h0, chg}, 32'h5);
        wr(2'b01, 32'h0);
        wr(2'b00, 32'h0);

        // R2 R3 R4 stream sweep over enable masks, global on and off
        for (int g = 0; g < 2; g++) begin
            for (int e = 0; e < 256; e += 17) begin
                k = {g[0], 23'h0, e[7:0]};
                wr(2'b00, k);
                for (int p = 0; p < 256; p++) begin
                    sdone = p[7:0];
                    @(negedge clk);
                    chk("R2 R3 sts stream", sts, model_sts(0, 0, 15'h5, 15'h0, p[7:0], k));
                    chk("R4 irq stream", {31'h0, irq},
                        {31'h0, (g == 1) && ((p & e) != 0)});
                end
            end
        end
        sdone = '0;

        // R1 controller summary: ring flags x wake masks, bit30 on/off
        for (int c = 0; c < 2; c++) begin
            k = c ? 32'hc000_0000 : 32'h8000_0000;
            wr(2'b00, k);
            for (int w = 0; w < 5; w++) begin
                wr(2'b01, {17'h0, wm[w]});
                for (int r = 0; r < 4; r++) begin
                    rsp_irq = r[0]; rsp_ovr = r[1];
                    @(negedge clk);
                    chk("R1 sts ctl", sts, model_sts(r[0], r[1], 15'h5, wm[w], 8'h0, k));
                    chk("R4 irq ctl", {31'h0, irq},
                        {31'h0, (c == 1) && (r != 0 || (wm[w] & 15'h5) != 0)});
                end
            end
        end
        rsp_irq = 0; rsp_ovr = 0;

        // R6 W1C and event priority
        wr(2'b10, 32'h0000_0001);
        chk("R6 clear bit0", {17'h0, chg}, 32'h4);
        cevt = 15'h0004;
        wr(2'b10, 32'h0000_0004);
        cevt = '0;
        chk("R6 event wins", {17'h0, chg}, 32'h4);
        cevt = 15'h0100;
        @(negedge clk);
        cevt = '0;
        chk("R6 event sets", {17'h0, chg}, 32'h104);

        // R10 clearing the last live source
        wr(2'b01, 32'h0000_0004);
        wr(2'b00, 32'hc000_0000);
        @(negedge clk);
        chk("R10 irq high", {31'h0, irq}, 32'h1);
        wr(2'b10, 32'h0000_0004);
        chk("R10 sts drop", sts, 32'h0);
        chk("R4 irq lag", {31'h0, irq}, 32'h1);
        @(negedge clk);
        chk("R10 irq low", {31'h0, irq}, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule